// File: doc/BRIEF.md
# Link Port Receive Word Assembler

This block is the receive side of a point-to-point link port. A transmitter drives a strobe clock together with a 4-bit or 8-bit data group. The receiver moves both into the core clock domain and samples the data on each falling edge of the strobe. It packs consecutive samples into 32-bit or 48-bit words and places each finished word into a two-entry first-in first-out buffer, where the host core reads it.

The receiver controls the acknowledge line. It drops acknowledge whenever the buffer has no room for another word, which holds off the transmitter. When the host reads and an entry is freed, acknowledge rises again. The host side has a one-cycle read strobe and registered read results. Empty and not-empty flags give the buffer state. An interrupt line is active while data is waiting, unless a bulk-transfer engine owns the port.

Configuration inputs (`enable`, `wide_path`, `long_word`) are expected to change only while `enable` is low. The core clock must run at least twice as fast as the strobe, because falling edges are detected after synchronisation.

Top module: `lport_rx`

## Requirements
- R1: The data group is captured on each falling edge of `link_clk`, after a two-stage synchroniser. A value driven at the rising edge and held through the low phase is the value taken.
- R2: The number of samples per word depends on the mode. A word takes 8 samples for 4-bit/32-bit, 12 for 4-bit/48-bit, 4 for 8-bit/32-bit and 6 for 8-bit/48-bit. In 4-bit mode only `link_dat[3:0]` is used. The first sample fills the least significant bits, and each later sample fills the next higher group. In 32-bit mode, `rd_data[47:32]` reads as zero.
- R3: The buffer holds up to two words and returns them in arrival order. A stored word is never overwritten.
- R4: `link_ack` is low whenever two words are stored. It is also low when one word is stored and a new word is partly assembled. While `enable` is high and neither case holds, `link_ack` is high.
- R5: `irq` is high while the buffer holds at least one word and `dma_on` is low. It is low while `dma_on` is high.
- R6: A read strobe taken while the buffer is empty gives, one cycle later, `rd_err`=1, `rd_valid`=0 and `rd_data`=0. It removes nothing from the buffer.
- R7: A read of a stored word gives that word one cycle later with `rd_valid`=1. If the read frees the entry that was blocking, `link_ack` is high in the following cycle.
- R8: While `enable` is low, `link_ack` is low and any partly assembled word is discarded. After `enable` rises, assembly starts again at sample zero.
- R9: When a word finishes in the same cycle as a read, with one word stored, both actions complete. The read returns the older word, the new word is stored, and neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low clears the assembly state |
| wide_path | input | 1 | 1: 8-bit data group, 0: 4-bit |
| long_word | input | 1 | 1: 48-bit words, 0: 32-bit |
| dma_on | input | 1 | Bulk-transfer engine owns the port; masks irq |
| link_clk | input | 1 | Strobe clock from the transmitter |
| link_dat | input | 8 | Data group from the transmitter |
| link_ack | output | 1 | Acknowledge / hold-off to the transmitter |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 48 | Word returned by the last read |
| rd_valid | output | 1 | Last read returned a word |
| rd_err | output | 1 | Last read found the buffer empty |
| buf_empty | output | 1 | Buffer holds no word |
| buf_nempty | output | 1 | Buffer holds at least one word |
| irq | output | 1 | Data-waiting interrupt |

## Verification
The two operations that can fall in the same cycle are completing a word into the buffer and a host read that pops it. The bench first preloads one word. It then times a read at each of several core-cycle offsets around the final falling edge of the next word, so that one offset lands exactly on the push. In every case the read must return the preloaded word, the buffer must still be non-empty, and a second read must return the new word followed by an empty-read error. Random traffic in all four modes repeats this with random offsets.

// File: rtl/lport_rx_pkg.sv
package lport_rx_pkg;
  localparam int DAT_W     = 8;
  localparam int NIB_W     = 4;
  localparam int WORD_W    = 48;
  localparam int BUF_DEPTH = 2;
  localparam int CNT_W     = 4;

  typedef logic [1:0]        fill_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  // samples needed for one word in the selected mode
  function automatic cnt_t beats_per_word(input logic wide, input logic long_w);
    if (long_w) return wide ? cnt_t'(6) : cnt_t'(12);
    else        return wide ? cnt_t'(4) : cnt_t'(8);
  endfunction

  // place one sample at slot idx of the accumulating word
  function automatic word_t merge_beat(input word_t acc, input cnt_t idx,
                                       input logic [DAT_W-1:0] d, input logic wide);
    word_t ext;
    int unsigned sh;
    ext = wide ? word_t'(d) : word_t'(d[NIB_W-1:0]);
    sh  = wide ? (32'(idx) << 3) : (32'(idx) << 2);
    return acc | (ext << sh);
  endfunction
endpackage

// File: rtl/lport_rx_sync.sv
module lport_rx_sync #(
  parameter int DEPTH = 2,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_clk,
  input  logic [DW-1:0] link_dat,
  output logic          fall,
  output logic [DW-1:0] dat_q
);
  logic [DEPTH:0]  ck_sr;
  logic [DW-1:0]   dat_sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_sr <= '0;
    else        ck_sr <= {ck_sr[DEPTH-1:0], link_clk};
  end

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_dat
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dat_sr[s] <= '0;
        else if (s == 0) dat_sr[s] <= link_dat;
        else             dat_sr[s] <= dat_sr[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // falling edge seen one stage past the synchroniser output
  assign fall  = ck_sr[DEPTH] & ~ck_sr[DEPTH-1];
  assign dat_q = dat_sr[DEPTH-1];
endmodule

// File: rtl/lport_rx_asm.sv
module lport_rx_asm
  import lport_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wide,
  input  logic             long_w,
  input  logic             fall,
  input  logic [DAT_W-1:0] dat,
  output logic             beat,
  output logic             word_done,
  output word_t            word,
  output logic             busy,
  output cnt_t             beat_cnt
);
  word_t acc;
  cnt_t  last_idx;

  assign last_idx  = beats_per_word(wide, long_w) - cnt_t'(1);
  assign beat      = enable & fall;
  assign word      = merge_beat(acc, beat_cnt, dat, wide);
  assign word_done = beat & (beat_cnt == last_idx);
  assign busy      = (beat_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      acc      <= '0;
    end else if (!enable) begin
      beat_cnt <= '0;
      acc      <= '0;
    end else if (word_done) begin
      beat_cnt <= '0;
      acc      <= '0;
    end else if (beat) begin
      beat_cnt <= beat_cnt + cnt_t'(1);
      acc      <= word;
    end
  end
endmodule

// File: rtl/lport_rx_buf.sv
module lport_rx_buf
  import lport_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  word_t push_data,
  input  logic  pop,
  output word_t head,
  output fill_t fill,
  output logic  drop
);
  word_t mem [BUF_DEPTH];
  logic  wp, rp, accept, pop_ok;

  assign pop_ok = pop & (fill != fill_t'(0));
  assign accept = push & ((fill != fill_t'(BUF_DEPTH)) | pop_ok);
  assign drop   = push & ~accept;
  assign head   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= 1'b0;
      rp   <= 1'b0;
      fill <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (accept) begin
        mem[wp] <= push_data;
        wp      <= ~wp;
      end
      if (pop_ok) rp <= ~rp;
      fill <= fill + fill_t'(accept) - fill_t'(pop_ok);
    end
  end
endmodule

// File: rtl/lport_rx.sv
module lport_rx
  import lport_rx_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        wide_path,
  input  logic        long_word,
  input  logic        dma_on,
  input  logic        link_clk,
  input  logic [7:0]  link_dat,
  output logic        link_ack,
  input  logic        rd_en,
  output logic [47:0] rd_data,
  output logic        rd_valid,
  output logic        rd_err,
  output logic        buf_empty,
  output logic        buf_nempty,
  output logic        irq
);
  logic             fall, beat, push, busy, pop_ok, drop, buf_full;
  logic [DAT_W-1:0] dat_sync;
  word_t            word, head;
  cnt_t             beat_cnt;
  fill_t            fill_lvl;

  lport_rx_sync #(.DEPTH(SYNC_DEPTH), .DW(DAT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_dat(link_dat),
    .fall(fall), .dat_q(dat_sync)
  );

  lport_rx_asm u_asm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wide(wide_path), .long_w(long_word),
    .fall(fall), .dat(dat_sync), .beat(beat), .word_done(push), .word(word),
    .busy(busy), .beat_cnt(beat_cnt)
  );

  lport_rx_buf u_buf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(word), .pop(rd_en),
    .head(head), .fill(fill_lvl), .drop(drop)
  );

  assign pop_ok     = rd_en & (fill_lvl != fill_t'(0));
  assign buf_empty  = (fill_lvl == fill_t'(0));
  assign buf_nempty = ~buf_empty;
  assign buf_full   = (fill_lvl == fill_t'(BUF_DEPTH)) |
                      ((fill_lvl == fill_t'(BUF_DEPTH-1)) & busy);
  assign link_ack   = enable & ~buf_full;
  assign irq        = buf_nempty & ~dma_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop_ok;
      rd_err   <= rd_en & buf_empty;
      if (rd_en) rd_data <= buf_empty ? '0 : head;
    end
  end
endmodule

// File: rtl/lport_rx_chk.sv
module lport_rx_chk
  import lport_rx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        link_ack,
  input logic        rd_en,
  input logic        rd_err,
  input logic [47:0] rd_data,
  input logic        buf_empty,
  input fill_t       fill_lvl,
  input logic        push,
  input logic        pop_ok,
  input logic        drop,
  input logic        busy,
  input logic        beat,
  input cnt_t        beat_cnt
);
  // R3: a finished word is never discarded
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) !drop);
  // R3: occupancy stays within two entries
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) fill_lvl <= fill_t'(BUF_DEPTH));
  // R4: hold-off with both entries used
  p_ack_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == fill_t'(BUF_DEPTH)) |-> !link_ack);
  // R4: hold-off with one entry used and a word under way
  p_ack_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == fill_t'(1) && busy) |-> !link_ack);
  // R6: empty read flagged and returns zero
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && buf_empty) |=> (rd_err && rd_data == '0));
  // R7: freeing an entry restores acknowledge
  p_ack_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fill_lvl == fill_t'(BUF_DEPTH) && pop_ok && !push && !beat && !busy) |=> link_ack);
  // R8: assembly restarts at sample zero after enable rises
  p_start_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (beat_cnt == '0));
  // R9: simultaneous push and pop with one word keeps the level
  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_ok && fill_lvl == fill_t'(1)) |=> (fill_lvl == fill_t'(1)));
endmodule

bind lport_rx lport_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .link_ack(link_ack), .rd_en(rd_en),
  .rd_err(rd_err), .rd_data(rd_data), .buf_empty(buf_empty), .fill_lvl(fill_lvl),
  .push(push), .pop_ok(pop_ok), .drop(drop), .busy(busy), .beat(beat), .beat_cnt(beat_cnt)
);

// File: tb/lport_rx_tb_top.sv
module lport_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, enable, wide_path, long_word, dma_on, link_clk, rd_en;
  logic [7:0]  link_dat;
  logic        link_ack, rd_valid, rd_err, buf_empty, buf_nempty, irq;
  logic [47:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [47:0] mq[$];
  logic [47:0] pend_exp;
  bit pend_empty;

  always #4 clk = ~clk;

  lport_rx dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wide_path(wide_path),
    .long_word(long_word), .dma_on(dma_on), .link_clk(link_clk), .link_dat(link_dat),
    .link_ack(link_ack), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_err(rd_err), .buf_empty(buf_empty), .buf_nempty(buf_nempty), .irq(irq)
  );

  function automatic int nbeats(input logic w, input logic l);
    return (l ? 48 : 32) / (w ? 8 : 4);
  endfunction

  function automatic logic [7:0] slice_of(input logic [47:0] w, input int i, input logic wd);
    return wd ? w[i*8 +: 8] : {4'h0, w[i*4 +: 4]};
  endfunction

  function automatic logic [47:0] rand_word(input logic l);
    logic [47:0] v;
    v = {$urandom(), $urandom()};
    return l ? v : {16'h0, v[31:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_issue();
    rd_en = 1'b1;
    pend_empty = (mq.size() == 0);
    pend_exp = pend_empty ? 48'h0 : mq.pop_front();
  endtask

  task automatic rd_judge(input string req);
    rd_en = 1'b0;
    if (pend_empty)
      chk(rd_err && !rd_valid && rd_data == 48'h0, {req, " empty read"}, {rd_err, rd_valid, rd_data[45:0]}, {2'b10, 46'h0});
    else
      chk(rd_valid && !rd_err && rd_data == pend_exp, {req, " read data"}, rd_data, pend_exp);
  endtask

  task automatic read_chk(input string req);
    @(negedge clk); rd_issue();
    @(negedge clk); rd_judge(req);
  endtask

  // send samples start..end of word w; optional read at offset rd_at after last fall
  task automatic send_word(input logic [47:0] w, input int start, input int stop, input int rd_at);
    bit pend;
    pend = 0;
    for (int i = start; i < stop; i++) begin
      @(negedge clk); link_dat = slice_of(w, i, wide_path); link_clk = 1'b1;
      repeat (4) @(negedge clk);
      link_clk = 1'b0;
      if (i == stop - 1) begin
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          if (pend) begin rd_judge("R9"); pend = 0; end
          if (k == rd_at) begin rd_issue(); pend = 1; end
        end
      end else repeat (3) @(negedge clk);
    end
  endtask

  task automatic full_word(input logic [47:0] w, input int rd_at);
    send_word(w, 0, nbeats(wide_path, long_word), rd_at);
    mq.push_back(w);
  endtask

  task automatic set_mode(input logic wd, input logic l);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); wide_path = wd; long_word = l;
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] w;
    void'($urandom(32'd20240611));
    rst_n = 0; enable = 0; wide_path = 0; long_word = 0; dma_on = 0;
    link_clk = 0; link_dat = 0; rd_en = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, disabled
    chk(!link_ack, "R8 ack low when disabled", link_ack, 0);
    chk(buf_empty && !buf_nempty, "R3 empty after reset", {buf_empty, buf_nempty}, 2'b10);
    chk(!irq && !rd_valid && !rd_err, "R5 no irq after reset", {irq, rd_valid, rd_err}, 0);
    enable = 1;
    @(negedge clk);
    chk(link_ack, "R4 ack high when empty", link_ack, 1);

    // 4-bit, 32-bit words
    full_word(48'h0000_A1B2_C3D4, -1);
    chk(buf_nempty && irq, "R5 irq with data", {buf_nempty, irq}, 2'b11);
    chk(link_ack, "R4 ack with one word idle", link_ack, 1);
    full_word(48'h0000_5E6F_7081, -1);
    chk(!link_ack, "R4 ack low when two stored", link_ack, 0);
    read_chk("R3");
    chk(link_ack, "R7 ack back after read", link_ack, 1);

    // partial word with one stored
    w = 48'h0000_9876_5432;
    send_word(w, 0, 1, -1);
    chk(!link_ack, "R4 ack low one stored plus partial", link_ack, 0);
    read_chk("R3");
    chk(link_ack, "R7 ack back after freeing", link_ack, 1);
    send_word(w, 1, 8, -1);
    mq.push_back(w);
    read_chk("R1");
    read_chk("R6");
    chk(!irq && buf_empty, "R5 irq drops when empty", {irq, buf_empty}, 2'b01);

    // interrupt masked
    dma_on = 1;
    full_word(48'h0000_1357_9BDF, -1);
    chk(!irq && buf_nempty, "R5 irq masked by dma_on", {irq, buf_nempty}, 2'b01);
    read_chk("R5");
    dma_on = 0;

    // enable drop clears partial assembly
    send_word(48'h0000_FFFF_FFFF, 0, 3, -1);
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk(!link_ack, "R8 ack low while disabled", link_ack, 0);
    enable = 1;
    @(negedge clk);
    full_word(48'h0000_0246_8ACE, -1);
    read_chk("R8");

    // all modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      full_word(rand_word(m[0]), -1);
      full_word(rand_word(m[0]), -1);
      read_chk("R2");
      read_chk("R2");
      read_chk("R6");
    end

    // push and pop in the same cycle
    set_mode(1, 1);
    for (int off = 0; off < 4; off++) begin
      full_word(rand_word(1), -1);
      full_word(rand_word(1), off);
      chk(buf_nempty, "R9 new word kept", buf_nempty, 1);
      read_chk("R9");
      read_chk("R9");
    end

    // random traffic
    for (int n = 0; n < 240; n++) begin
      if (n % 40 == 0) begin
        while (mq.size() != 0) read_chk("R3");
        set_mode($urandom_range(0, 1), $urandom_range(0, 1));
      end
      if (mq.size() == 2 || $urandom_range(0, 3) == 0) read_chk("R3");
      if (mq.size() < 2) begin
        chk(link_ack, "R4 ack ready before word", link_ack, 1);
        full_word(rand_word(long_word), (mq.size() != 0 && $urandom_range(0, 1) == 1) ? int'($urandom_range(0, 3)) : -1);
      end
    end
    while (mq.size() != 0) read_chk("R3");
    read_chk("R6");
    finish_run();
  end
endmodule